// File: doc/BRIEF.md
# Triggered Dual-Lane Sample Capture Engine

The engine takes the output of a two-lane high-speed converter. Each lane is 8 bits wide and double-data-rate, so the block sees one sample on the rising edge and one on the falling edge of each clock. It packs each lane's bytes into 64-bit words and holds them in an on-chip two-bank buffer. Software chooses one of two modes. In dual mode the lanes are two separate channels. In interleaved mode the lanes are one channel running at twice the per-lane rate, and their samples are merged in time order.

Capture is armed by a pulse. While armed, the engine watches one selected lane for a crossing of a programmable 8-bit threshold in a programmed direction. Nothing is written before that crossing. After the crossing, a programmed number of words is written, the engine stops and raises a done flag, and the buffer can be read back through a registered read port. The length that can be programmed is capped by the capacity of the buffer.

Top module: `adc_capture_engine`

## Requirements
- R1: After reset, `armed_o`, `busy_o` and `done_o` are all 0.
- R2: Dual mode packing. Each lane word is built from 4 clocks of that lane. The earliest sample goes in byte 0 (bits 7:0), and within a clock the rising-edge byte comes before the falling-edge byte. The word number k counts from 0 at the start of the capture. Lane A word k goes to bank 0 at address k, and lane B word k goes to bank 1 at address k.
- R3: Interleaved mode packing. A word spans 2 clocks, and each clock adds 4 bytes in the order A rise, B rise, A fall, B fall, starting at byte 0. Word k goes to bank k mod 2 at address k/2.
- R4: While idle or armed, the buffer contents do not change.
- R5: A rising trigger fires when one sample of the selected lane is below the threshold and the next sample is at or above it. The pair may lie inside one clock, or span the previous falling byte and the current rising byte. In the first armed clock, only a pair inside that clock counts. `busy_o` goes high in the clock after the trigger.
- R6: A falling trigger fires when one sample is at or above the threshold and the next sample is below it.
- R7: The first stored word starts with the rising-edge sample of the clock after the trigger clock.
- R8: Exactly the latched number of words is written. `done_o` rises in the clock after the last write and `busy_o` falls at the same time. Later buffer locations are left untouched.
- R9: The length is latched when the engine is armed. A length of 0 is treated as 1. Lengths above the capacity are cut to the capacity, which is DEPTH words in dual mode and 2*DEPTH words in interleaved mode.
- R10: Once a capture has started, crossings are ignored and `done_o` stays high until the engine is re-armed. Arming clears `done_o` and sets `armed_o` on the next clock.
- R11: `rd_data_o` presents the word at `rd_bank_i`/`rd_addr_i` one clock after they are applied. It does not change before that clock edge.
- R12: Only the lane chosen by `cfg_trig_lane_i` (0 = A, 1 = B) can fire the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_rise_i | input | 8 | Lane A byte taken on the rising edge |
| a_fall_i | input | 8 | Lane A byte taken on the falling edge |
| b_rise_i | input | 8 | Lane B byte taken on the rising edge |
| b_fall_i | input | 8 | Lane B byte taken on the falling edge |
| cfg_interleave_i | input | 1 | 1 = interleaved mode, latched at arm |
| cfg_trig_lane_i | input | 1 | Lane that can fire the trigger |
| cfg_trig_falling_i | input | 1 | 1 = falling crossing, 0 = rising crossing |
| cfg_thresh_i | input | 8 | Trigger threshold |
| cfg_length_i | input | LEN_W | Number of words to store, latched at arm |
| arm_i | input | 1 | Pulse that arms or re-arms the engine |
| armed_o | output | 1 | Waiting for a trigger |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | Capture complete |
| rd_bank_i | input | 1 | Bank to read |
| rd_addr_i | input | AW | Word address to read |
| rd_data_o | output | 64 | Read data, one clock after the address |

## Verification
The bench builds the engine with DEPTH = 8. With that size, a full-buffer capture in dual mode takes 32 clocks, so both length limits (the clamp at 8 and at 16 words, and the zero-to-one case) are reached quickly. It also means that every location of both banks can be compared against a reference model after every scenario. That full comparison shows where each capture stopped, and that idle periods and ignored crossings left the buffer unchanged.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CAPTURE,
    ST_DONE
  } cap_state_e;

  // early -> late sample pair crosses thr in the chosen direction
  function automatic logic crossed(input logic [7:0] early, input logic [7:0] late,
                                   input logic [7:0] thr, input logic falling);
    if (falling) return (early >= thr) && (late < thr);
    return (early < thr) && (late >= thr);
  endfunction
endpackage

// File: rtl/adc_level_trigger.sv
module adc_level_trigger
  import adc_cap_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          clear_i,
  input  logic          lane_sel_i,
  input  logic          falling_i,
  input  logic [SW-1:0] thr_i,
  input  logic [SW-1:0] a_rise_i,
  input  logic [SW-1:0] a_fall_i,
  input  logic [SW-1:0] b_rise_i,
  input  logic [SW-1:0] b_fall_i,
  output logic          hit_o
);
  logic [SW-1:0] rise, fall, prev_q;
  logic          prev_ok_q;

  assign rise = lane_sel_i ? b_rise_i : a_rise_i;
  assign fall = lane_sel_i ? b_fall_i : a_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else begin
      prev_q    <= fall;
      prev_ok_q <= !clear_i;
    end
  end

  assign hit_o = enable_i &&
                 ((prev_ok_q && crossed(prev_q, rise, thr_i, falling_i)) ||
                  crossed(rise, fall, thr_i, falling_i));
endmodule

// File: rtl/adc_word_packer.sv
module adc_word_packer #(
  parameter int SW     = 8,
  parameter int WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              interleave_i,
  input  logic [SW-1:0]     a_rise_i,
  input  logic [SW-1:0]     a_fall_i,
  input  logic [SW-1:0]     b_rise_i,
  input  logic [SW-1:0]     b_fall_i,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic              full_o
);
  localparam int LANE_STEPS = WORD_W / (2 * SW);
  localparam int ILV_STEPS  = WORD_W / (4 * SW);
  localparam int PH_W       = $clog2(LANE_STEPS) + 1;

  logic [WORD_W-1:0] sh_a_q, sh_b_q;
  logic [PH_W-1:0]   phase_q, last_ph;

  // newest bytes enter at the top, so the earliest ends up in byte 0
  always_comb begin
    if (interleave_i) begin
      word_a_o = {b_fall_i, a_fall_i, b_rise_i, a_rise_i, sh_a_q[WORD_W-1:4*SW]};
      word_b_o = sh_b_q;
    end else begin
      word_a_o = {a_fall_i, a_rise_i, sh_a_q[WORD_W-1:2*SW]};
      word_b_o = {b_fall_i, b_rise_i, sh_b_q[WORD_W-1:2*SW]};
    end
  end

  assign last_ph = interleave_i ? PH_W'(ILV_STEPS - 1) : PH_W'(LANE_STEPS - 1);
  assign full_o  = shift_i && (phase_q == last_ph);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_a_q  <= '0;
      sh_b_q  <= '0;
      phase_q <= '0;
    end else if (clear_i) begin
      phase_q <= '0;
    end else if (shift_i) begin
      sh_a_q  <= word_a_o;
      sh_b_q  <= word_b_o;
      phase_q <= full_o ? '0 : phase_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/adc_capture_buffer.sv
module adc_capture_buffer #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 64,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic [1:0]        we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata0_i,
  input  logic [WORD_W-1:0] wdata1_i,
  input  logic              rd_bank_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] rd_q [2];
  logic              bank_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] wdata;
    assign wdata = (b == 0) ? wdata0_i : wdata1_i;
    always_ff @(posedge clk_i) begin
      if (we_i[b]) mem[waddr_i] <= wdata;
      rd_q[b] <= mem[rd_addr_i];
    end
  end

  always_ff @(posedge clk_i) bank_q <= rd_bank_i;

  assign rd_data_o = bank_q ? rd_q[1] : rd_q[0];
endmodule

// File: rtl/adc_capture_engine.sv
module adc_capture_engine
  import adc_cap_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SW     = 8,
  parameter int WORD_W = 64,
  parameter int AW     = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(2 * DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     a_rise_i,
  input  logic [SW-1:0]     a_fall_i,
  input  logic [SW-1:0]     b_rise_i,
  input  logic [SW-1:0]     b_fall_i,
  input  logic              cfg_interleave_i,
  input  logic              cfg_trig_lane_i,
  input  logic              cfg_trig_falling_i,
  input  logic [SW-1:0]     cfg_thresh_i,
  input  logic [LEN_W-1:0]  cfg_length_i,
  input  logic              arm_i,
  output logic              armed_o,
  output logic              busy_o,
  output logic              done_o,
  input  logic              rd_bank_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam logic [LEN_W-1:0] CAP_DUAL = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] CAP_ILV  = LEN_W'(2 * DEPTH);

  cap_state_e        state_q;
  logic [LEN_W-1:0]  wcount_q, len_q, eff_len, cap;
  logic              mode_q, hit, capturing, wr_evt;
  logic [WORD_W-1:0] word_a, word_b;
  logic [1:0]        we;
  logic [AW-1:0]     waddr;

  assign capturing = (state_q == ST_CAPTURE);

  adc_level_trigger #(.SW(SW)) i_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   ((state_q == ST_ARMED) && !arm_i),
    .clear_i    (arm_i),
    .lane_sel_i (cfg_trig_lane_i),
    .falling_i  (cfg_trig_falling_i),
    .thr_i      (cfg_thresh_i),
    .a_rise_i   (a_rise_i),
    .a_fall_i   (a_fall_i),
    .b_rise_i   (b_rise_i),
    .b_fall_i   (b_fall_i),
    .hit_o      (hit)
  );

  adc_word_packer #(.SW(SW), .WORD_W(WORD_W)) i_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (hit),
    .shift_i      (capturing),
    .interleave_i (mode_q),
    .a_rise_i     (a_rise_i),
    .a_fall_i     (a_fall_i),
    .b_rise_i     (b_rise_i),
    .b_fall_i     (b_fall_i),
    .word_a_o     (word_a),
    .word_b_o     (word_b),
    .full_o       (wr_evt)
  );

  // interleaved words alternate banks so both modes fill the same storage
  always_comb begin
    we = 2'b00;
    if (wr_evt) we = mode_q ? (wcount_q[0] ? 2'b10 : 2'b01) : 2'b11;
    waddr = mode_q ? wcount_q[AW:1] : wcount_q[AW-1:0];
  end

  adc_capture_buffer #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) i_buf (
    .clk_i     (clk_i),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata0_i  (word_a),
    .wdata1_i  (mode_q ? word_a : word_b),
    .rd_bank_i (rd_bank_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  always_comb begin
    cap = cfg_interleave_i ? CAP_ILV : CAP_DUAL;
    if (cfg_length_i == '0)     eff_len = LEN_W'(1);
    else if (cfg_length_i > cap) eff_len = cap;
    else                         eff_len = cfg_length_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wcount_q <= '0;
      len_q    <= '0;
      mode_q   <= 1'b0;
    end else if (arm_i) begin
      state_q  <= ST_ARMED;
      wcount_q <= '0;
      len_q    <= eff_len;
      mode_q   <= cfg_interleave_i;
    end else begin
      case (state_q)
        ST_ARMED: if (hit) state_q <= ST_CAPTURE;
        ST_CAPTURE: if (wr_evt) begin
          wcount_q <= wcount_q + LEN_W'(1);
          if (wcount_q + LEN_W'(1) == len_q) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign armed_o = (state_q == ST_ARMED);
  assign busy_o  = capturing;
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/adc_capture_engine_chk.sv
module adc_capture_engine_chk #(
  parameter int DEPTH = 16,
  parameter int LEN_W = $clog2(2 * DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             armed_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             wr_evt_i,
  input logic [LEN_W-1:0] len_i,
  input logic             mode_i
);
  logic [LEN_W-1:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_cnt_q <= '0;
    else if (arm_i)    wr_cnt_q <= '0;
    else if (wr_evt_i) wr_cnt_q <= wr_cnt_q + LEN_W'(1);
  end

  AST_ONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({armed_o, busy_o, done_o})); // R10
  AST_ARM_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> armed_o && !done_o); // R10
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !arm_i |=> done_o); // R10
  AST_CAPTURE_AFTER_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(armed_o)); // R5
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_i |-> busy_o); // R4
  AST_LEN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> wr_cnt_q == len_i); // R8
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> (len_i != '0) &&
                (len_i <= (mode_i ? LEN_W'(2 * DEPTH) : LEN_W'(DEPTH)))); // R9
endmodule

bind adc_capture_engine adc_capture_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .arm_i    (arm_i),
  .armed_o  (armed_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .wr_evt_i (wr_evt),
  .len_i    (len_q),
  .mode_i   (mode_q)
);

// File: tb/test_adc_capture_engine.sv
module test_adc_capture_engine;
  localparam int DEPTH = 8;
  localparam int AW    = 3;
  localparam int LEN_W = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a_rise_i = '0, a_fall_i = '0, b_rise_i = '0, b_fall_i = '0;
  logic        cfg_interleave_i = 1'b0, cfg_trig_lane_i = 1'b0, cfg_trig_falling_i = 1'b0;
  logic [7:0]  cfg_thresh_i = 8'h80;
  logic [LEN_W-1:0] cfg_length_i = '0;
  logic        arm_i = 1'b0;
  logic        armed_o, busy_o, done_o;
  logic        rd_bank_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [63:0] rd_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] m0 [DEPTH];
  logic [63:0] m1 [DEPTH];

  always #5 clk_i = ~clk_i;

  adc_capture_engine #(.DEPTH(DEPTH)) i_adc_capture_engine (
    .clk_i, .rst_ni, .a_rise_i, .a_fall_i, .b_rise_i, .b_fall_i,
    .cfg_interleave_i, .cfg_trig_lane_i, .cfg_trig_falling_i, .cfg_thresh_i,
    .cfg_length_i, .arm_i, .armed_o, .busy_o, .done_o,
    .rd_bank_i, .rd_addr_i, .rd_data_o
  );

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [7:0] a_s(int seed, int n);
    return 8'(n * 3 + seed * 17);
  endfunction
  function automatic logic [7:0] b_s(int seed, int n);
    return 8'(n * 5 + seed * 29 + 3);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req, logic ar, logic bu, logic dn);
    chk(req, {61'd0, armed_o, busy_o, done_o}, {61'd0, ar, bu, dn});
  endtask

  task automatic step(logic [7:0] ar, logic [7:0] af, logic [7:0] br, logic [7:0] bf);
    a_rise_i = ar; a_fall_i = af; b_rise_i = br; b_fall_i = bf;
    @(negedge clk_i);
  endtask

  task automatic stream(int first, int n, int seed);
    for (int k = first; k < first + n; k++)
      step(a_s(seed, 2*k), a_s(seed, 2*k+1), b_s(seed, 2*k), b_s(seed, 2*k+1));
  endtask

  task automatic arm(logic intl, logic lane, logic fall, logic [7:0] thr, int len);
    cfg_interleave_i = intl; cfg_trig_lane_i = lane; cfg_trig_falling_i = fall;
    cfg_thresh_i = thr; cfg_length_i = LEN_W'(len);
    arm_i = 1'b1;
    step(8'h00, 8'h00, 8'h00, 8'h00);
    arm_i = 1'b0;
  endtask

  task automatic model_store(logic intl, int len, int seed);
    for (int w = 0; w < len; w++) begin
      logic [63:0] wa, wb;
      for (int j = 0; j < 8; j++) begin
        if (intl) begin
          int c = 2*w + j/4;
          case (j % 4)
            0: wa[8*j +: 8] = a_s(seed, 2*c);
            1: wa[8*j +: 8] = b_s(seed, 2*c);
            2: wa[8*j +: 8] = a_s(seed, 2*c+1);
            default: wa[8*j +: 8] = b_s(seed, 2*c+1);
          endcase
        end else begin
          wa[8*j +: 8] = a_s(seed, 8*w + j);
          wb[8*j +: 8] = b_s(seed, 8*w + j);
        end
      end
      if (intl) begin
        if (w % 2 == 0) m0[w/2] = wa; else m1[w/2] = wa;
      end else begin
        m0[w] = wa; m1[w] = wb;
      end
    end
  endtask

  task automatic read_word(logic bank, int addr, output logic [63:0] d);
    rd_bank_i = bank; rd_addr_i = AW'(addr);
    @(negedge clk_i);
    d = rd_data_o;
  endtask

  task automatic verify_mem(string req);
    logic [63:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      read_word(1'b0, a, d); chk(req, d, m0[a]);
      read_word(1'b1, a, d); chk(req, d, m1[a]);
    end
  endtask

  task automatic t_reset;
    chk_flags("R1", 1'b0, 1'b0, 1'b0);
  endtask

  // R2 R7 R8: full dual capture, in-clock rising crossing on lane A
  task automatic t_dual_fill;
    arm(1'b0, 1'b0, 1'b0, 8'h80, DEPTH);
    chk_flags("R10", 1'b1, 1'b0, 1'b0);
    step(8'h10, 8'h10, 8'h00, 8'h00);
    step(8'h10, 8'h90, 8'h00, 8'h00);
    chk_flags("R5", 1'b0, 1'b1, 1'b0);
    stream(0, 31, 1);
    chk_flags("R8", 1'b0, 1'b1, 1'b0);
    stream(31, 1, 1);
    chk_flags("R8", 1'b0, 1'b0, 1'b1);
    model_store(1'b0, DEPTH, 1);
    verify_mem("R2/R7");
  endtask

  // R4 R5 R12: armed without a valid crossing, then a cross-clock crossing
  task automatic t_idle_then_boundary;
    arm(1'b0, 1'b0, 1'b0, 8'h80, 3);
    step(8'h90, 8'h90, 8'h00, 8'hff);
    chk_flags("R5", 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++) step(8'h90, 8'ha0, 8'h00, 8'hff);
    step(8'h90, 8'h70, 8'h00, 8'hff);
    step(8'h70, 8'h70, 8'h00, 8'hff);
    chk_flags("R12", 1'b1, 1'b0, 1'b0);
    verify_mem("R4");
    step(8'h80, 8'h80, 8'h00, 8'h00);
    chk_flags("R5", 1'b0, 1'b1, 1'b0);
    stream(0, 12, 2);
    chk_flags("R8", 1'b0, 1'b0, 1'b1);
    model_store(1'b0, 3, 2);
    verify_mem("R8");
  endtask

  // R6 R12: falling crossing on lane B, at the threshold value
  task automatic t_falling_b;
    arm(1'b0, 1'b1, 1'b1, 8'h40, 2);
    step(8'h00, 8'hff, 8'h40, 8'h40);
    step(8'hff, 8'h00, 8'h40, 8'h40);
    chk_flags("R12", 1'b1, 1'b0, 1'b0);
    step(8'h00, 8'hff, 8'h40, 8'h3f);
    chk_flags("R6", 1'b0, 1'b1, 1'b0);
    stream(0, 8, 3);
    chk_flags("R6", 1'b0, 1'b0, 1'b1);
    model_store(1'b0, 2, 3);
    verify_mem("R6");
  endtask

  task automatic t_interleave;
    arm(1'b1, 1'b0, 1'b0, 8'h80, 5);
    step(8'h10, 8'h10, 8'h00, 8'h00);
    step(8'h10, 8'h80, 8'h00, 8'h00);
    stream(0, 9, 4);
    chk_flags("R3", 1'b0, 1'b1, 1'b0);
    stream(9, 1, 4);
    chk_flags("R3", 1'b0, 1'b0, 1'b1);
    model_store(1'b1, 5, 4);
    verify_mem("R3");
  endtask

  // R9: over-long dual length cut to DEPTH, zero interleaved length becomes 1
  task automatic t_clamp;
    arm(1'b0, 1'b0, 1'b0, 8'h80, 31);
    step(8'h10, 8'hf0, 8'h00, 8'h00);
    stream(0, 32, 5);
    chk_flags("R9", 1'b0, 1'b0, 1'b1);
    model_store(1'b0, DEPTH, 5);
    verify_mem("R9");
    arm(1'b1, 1'b0, 1'b0, 8'h80, 0);
    step(8'h10, 8'hf0, 8'h00, 8'h00);
    stream(0, 1, 6);
    chk_flags("R9", 1'b0, 1'b1, 1'b0);
    stream(1, 1, 6);
    chk_flags("R9", 1'b0, 1'b0, 1'b1);
    model_store(1'b1, 1, 6);
    verify_mem("R9");
  endtask

  task automatic t_retrigger;
    for (int k = 0; k < 10; k++) step(8'h00, 8'hff, 8'h00, 8'hff);
    chk_flags("R10", 1'b0, 1'b0, 1'b1);
    verify_mem("R10");
    arm(1'b0, 1'b0, 1'b0, 8'h80, 1);
    chk_flags("R10", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_read_latency;
    logic [63:0] d;
    read_word(1'b0, 1, d);
    chk("R11", d, m0[1]);
    rd_bank_i = 1'b1; rd_addr_i = AW'(2);
    @(posedge clk_i); #1;
    chk("R11", rd_data_o, m1[2]);
    @(negedge clk_i);
    rd_addr_i = AW'(3);
    #1;
    chk("R11", rd_data_o, m1[2]);
    @(negedge clk_i);
    chk("R11", rd_data_o, m1[3]);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_dual_fill;
    t_idle_then_boundary;
    t_falling_b;
    t_interleave;
    t_clamp;
    t_retrigger;
    t_read_latency;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule